// File: doc/BRIEF.md
# Serial Configuration Word Loader

This block receives configuration words over a three-pin serial port: a serial clock, a data line and a load strobe. The pins run asynchronously to the system clock. Each pin passes through a two-flop synchronizer, and the block then looks for edges on the synchronized copies. A data bit is captured on every rising edge of the serial clock. The bits fill a 24-bit shift register, most-significant bit first. When the load strobe rises, the three lowest bits of the shifted word give the address of the destination register. The upper 21 bits are written into that register. A mask parameter sets which of the eight addresses are implemented. A load to an address that is not implemented changes nothing.

Three control fields are decoded from the registers.
- The LO pin direction uses register 5 together with the external `lo_sel` pin.
- The charge-pump current code and the reference source come from register 4.

The serial timing is checked in system-clock cycles: the minimum serial clock phase, data setup and hold around a capture, the gap from a clock edge to the load strobe, and the load-strobe width. Each kind of violation raises its own one-cycle pulse. A violation never blocks a capture or a load.

The port has no data stream to carry back-pressure. Words arrive only as fast as the external master clocks them, so every pin is plain. Control outputs are held until the next load rewrites their register.

Top module: `cfgld_top`

## Requirements
- R1: After reset every register field, `cp_cur_code`, `cp_ext_ref`, `lo_pins_in` and `tviol` are 0.
- R2: Each rising edge of the synchronized serial clock shifts the synchronized data bit into the LSB end of a 24-bit shift register. The word is therefore assembled MSB first.
- R3: A rising edge of the synchronized load strobe writes word bits [23:3] into the register whose address is word bits [2:0]. The register occupies `cfg_words[addr*21 +: 21]`. The result is visible on the third system clock edge after the pin first reads high.
- R4: A load whose address is not implemented (default mask 8'hBF, so address 6 is not implemented) leaves every register unchanged. The slice of an unimplemented address reads 0.
- R5: If more or fewer than 24 bits are shifted before a load, the last 24 bits shifted in form the word. Bits left over from earlier words fill the older positions.
- R6: `lo_pins_out` = `lo_sel` OR (reg5 word bit 3 = 1 AND word bit 4 = 0). `lo_pins_in` = NOT `lo_sel` AND word bit 3 = 0 AND word bit 4 = 1. The two outputs are never both high.
- R7: `cp_cur_code` equals register 4 word bits [11:10] (0..3 select 250, 500, 750 and 1000 uA). `cp_ext_ref` equals register 4 word bit 18.
- R8: `tviol[0]` pulses when a synchronized serial clock level lasts fewer than `PHASE_MIN` cycles (default 2).
- R9: `tviol[1]` pulses in either of two cases. The data is not stable for `SETUP_MIN` cycles (default 1) up to and including a capture edge. Or the data changes within `HOLD_MIN` cycles (default 1) after a capture edge.
- R10: `tviol[2]` pulses when the load strobe rises fewer than `GAP_MIN` cycles (default 1) after a clock rise. `tviol[3]` pulses when a load strobe stays high for fewer than `LE_MIN` cycles (default 2). Neither violation blocks the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_le | input | 1 | Load strobe, asynchronous |
| lo_sel | input | 1 | External LO direction select |
| cfg_words | output | 168 | All eight 21-bit register fields, address 0 at the LSB end |
| lo_pins_out | output | 1 | LO pins are driven as outputs |
| lo_pins_in | output | 1 | LO pins act as inputs |
| cp_cur_code | output | 2 | Charge-pump current code |
| cp_ext_ref | output | 1 | External charge-pump reference selected |
| tviol | output | 4 | Timing-violation pulses: phase, data, strobe gap, strobe width |

## Verification
The hardest cases to reach from the pins are the ones where two pins move in the same synchronized cycle. One is a load strobe rising together with a serial clock edge. The other is data changing together with a capture edge or one cycle after it. Such cases decide which word is loaded and whether a pulse appears. The bench reaches them by driving those pins on the same or adjacent system clock falling edges. Both synchronizers have the same depth, so this alignment carries through to the edge detectors. The bench also shifts runs of 28 and 8 bits so that the load uses bits left over from the previous word.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  // word bit positions the decoders depend on
  localparam int LO_REG_ADDR  = 5;
  localparam int LO_DRV_BIT   = 3;
  localparam int LO_EXT_BIT   = 4;
  localparam int CP_REG_ADDR  = 4;
  localparam int CP_CODE_LSB  = 10;
  localparam int CP_REF_BIT   = 18;

  typedef enum int {
    TV_PHASE = 0,
    TV_DATA  = 1,
    TV_GAP   = 2,
    TV_WIDTH = 3
  } tviol_idx_e;
  localparam int TV_W = 4;
endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/cfgld_timing.sv
module cfgld_timing
  import cfgld_pkg::*;
#(
  parameter int CW        = 8,
  parameter int PHASE_MIN = 2,
  parameter int SETUP_MIN = 1,
  parameter int HOLD_MIN  = 1,
  parameter int GAP_MIN   = 1,
  parameter int LE_MIN    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s_clk,
  input  logic            s_dat,
  input  logic            s_le,
  output logic            bit_vld,
  output logic            load,
  output logic [TV_W-1:0] tviol
);
  localparam logic [CW:0]   PHASE_L = (CW+1)'(PHASE_MIN);
  localparam logic [CW:0]   SETUP_L = (CW+1)'(SETUP_MIN);
  localparam logic [CW:0]   GAP_L   = (CW+1)'(GAP_MIN);
  localparam logic [CW-1:0] LE_L    = CW'(LE_MIN);
  localparam logic [CW-1:0] HOLD_L  = CW'(HOLD_MIN);

  logic p_clk, p_dat, p_le;
  logic clk_rise, clk_edge, dat_chg, le_rise, le_fall;
  logic [CW-1:0] ph_cnt, dat_cnt, gap_cnt, le_cnt, hold_cnt;
  logic [CW:0]   stab_len, gap_len, ph_len;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] c);
    return (c == '1) ? c : c + 1'b1;
  endfunction

  assign clk_rise = s_clk & ~p_clk;
  assign clk_edge = s_clk ^ p_clk;
  assign dat_chg  = s_dat ^ p_dat;
  assign le_rise  = s_le & ~p_le;
  assign le_fall  = ~s_le & p_le;
  assign ph_len   = {1'b0, ph_cnt} + 1'b1;
  assign stab_len = dat_chg  ? '0 : {1'b0, dat_cnt} + 1'b1;
  assign gap_len  = clk_rise ? '0 : {1'b0, gap_cnt} + 1'b1;

  assign bit_vld = clk_rise;
  assign load    = le_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_clk    <= 1'b0;
      p_dat    <= 1'b0;
      p_le     <= 1'b0;
      ph_cnt   <= '1;
      dat_cnt  <= '1;
      gap_cnt  <= '1;
      le_cnt   <= '0;
      hold_cnt <= '0;
      tviol    <= '0;
    end else begin
      p_clk   <= s_clk;
      p_dat   <= s_dat;
      p_le    <= s_le;
      ph_cnt  <= clk_edge ? '0 : sat_inc(ph_cnt);
      dat_cnt <= dat_chg  ? '0 : sat_inc(dat_cnt);
      gap_cnt <= clk_rise ? '0 : sat_inc(gap_cnt);
      if (le_rise)   le_cnt <= CW'(1);
      else if (s_le) le_cnt <= sat_inc(le_cnt);
      if (clk_rise)              hold_cnt <= HOLD_L;
      else if (hold_cnt != '0)   hold_cnt <= hold_cnt - 1'b1;
      tviol[TV_PHASE] <= clk_edge && (ph_len < PHASE_L);
      tviol[TV_DATA]  <= (clk_rise && (stab_len < SETUP_L)) ||
                         (dat_chg && (hold_cnt != '0));
      tviol[TV_GAP]   <= le_rise && (gap_len < GAP_L);
      tviol[TV_WIDTH] <= le_fall && (le_cnt < LE_L);
    end
  end
endmodule

// File: rtl/cfgld_shift.sv
module cfgld_shift #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word <= '0;
    else if (bit_vld) word <= {word[WORD_W-2:0], bit_in};
  end
endmodule

// File: rtl/cfgld_regs.sv
module cfgld_regs #(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 3,
  parameter logic [(1<<ADDR_W)-1:0] IMPL_MASK = 8'hBF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic [WORD_W-1:0] word,
  output logic [(1<<ADDR_W)*(WORD_W-ADDR_W)-1:0] cfg_words
);
  localparam int NREG    = 1 << ADDR_W;
  localparam int FIELD_W = WORD_W - ADDR_W;

  logic [ADDR_W-1:0]  addr;
  logic [FIELD_W-1:0] field;
  assign addr  = word[ADDR_W-1:0];
  assign field = word[WORD_W-1:ADDR_W];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (IMPL_MASK[g]) begin : g_impl
      logic [FIELD_W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               r <= '0;
        else if (load && addr == ADDR_W'(g))      r <= field;
      end
      assign cfg_words[g*FIELD_W +: FIELD_W] = r;
    end else begin : g_none
      assign cfg_words[g*FIELD_W +: FIELD_W] = '0;
    end
  end
endmodule

// File: rtl/cfgld_top.sv
module cfgld_top
  import cfgld_pkg::*;
#(
  parameter int WORD_W    = 24,
  parameter int ADDR_W    = 3,
  parameter logic [(1<<ADDR_W)-1:0] IMPL_MASK = 8'hBF,
  parameter int SYNC_STG  = 2,
  parameter int CW        = 8,
  parameter int PHASE_MIN = 2,
  parameter int SETUP_MIN = 1,
  parameter int HOLD_MIN  = 1,
  parameter int GAP_MIN   = 1,
  parameter int LE_MIN    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_dat,
  input  logic ser_le,
  input  logic lo_sel,
  output logic [(1<<ADDR_W)*(WORD_W-ADDR_W)-1:0] cfg_words,
  output logic lo_pins_out,
  output logic lo_pins_in,
  output logic [1:0] cp_cur_code,
  output logic cp_ext_ref,
  output logic [TV_W-1:0] tviol
);
  localparam int FIELD_W = WORD_W - ADDR_W;
  localparam int LO_BASE = LO_REG_ADDR * FIELD_W;
  localparam int CP_BASE = CP_REG_ADDR * FIELD_W;

  logic [2:0] pins_s;
  logic bit_vld, load;
  logic [WORD_W-1:0] word;
  logic lo_drv, lo_ext;

  cfgld_sync #(.W(3), .STAGES(SYNC_STG)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .din({ser_le, ser_dat, ser_clk}), .dout(pins_s)
  );

  cfgld_timing #(
    .CW(CW), .PHASE_MIN(PHASE_MIN), .SETUP_MIN(SETUP_MIN),
    .HOLD_MIN(HOLD_MIN), .GAP_MIN(GAP_MIN), .LE_MIN(LE_MIN)
  ) tim_i (
    .clk(clk), .rst_n(rst_n),
    .s_clk(pins_s[0]), .s_dat(pins_s[1]), .s_le(pins_s[2]),
    .bit_vld(bit_vld), .load(load), .tviol(tviol)
  );

  cfgld_shift #(.WORD_W(WORD_W)) shf_i (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(pins_s[1]), .word(word)
  );

  cfgld_regs #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .IMPL_MASK(IMPL_MASK)) regs_i (
    .clk(clk), .rst_n(rst_n), .load(load), .word(word), .cfg_words(cfg_words)
  );

  assign lo_drv      = cfg_words[LO_BASE + LO_DRV_BIT - ADDR_W];
  assign lo_ext      = cfg_words[LO_BASE + LO_EXT_BIT - ADDR_W];
  assign lo_pins_out = lo_sel | (lo_drv & ~lo_ext);
  assign lo_pins_in  = ~lo_sel & ~lo_drv & lo_ext;
  assign cp_cur_code = cfg_words[CP_BASE + CP_CODE_LSB - ADDR_W +: 2];
  assign cp_ext_ref  = cfg_words[CP_BASE + CP_REF_BIT - ADDR_W];
endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk #(
  parameter int NREG    = 8,
  parameter int FIELD_W = 21,
  parameter int CP_ADDR = 4
) (
  input logic clk,
  input logic rst_n,
  input logic ser_le,
  input logic lo_sel,
  input logic lo_pins_out,
  input logic lo_pins_in,
  input logic [1:0] cp_cur_code,
  input logic [NREG*FIELD_W-1:0] cfg_words
);
  logic [NREG*FIELD_W-1:0] prev_q;
  logic [NREG-1:0] chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cfg_words;
  end

  always_comb begin
    for (int i = 0; i < NREG; i++)
      chg[i] = cfg_words[i*FIELD_W +: FIELD_W] != prev_q[i*FIELD_W +: FIELD_W];
  end

  // R3
  one_reg_per_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chg));

  // R3
  load_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|chg) |-> ($past(ser_le, 3) && !$past(ser_le, 4)));

  // R6
  lo_dir_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_pins_out && lo_pins_in));

  // R6
  lo_sel_forces_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_sel |-> (lo_pins_out && !lo_pins_in));

  // R7
  cp_code_moves_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_cur_code != $past(cp_cur_code)) |-> chg[CP_ADDR]);
endmodule

bind cfgld_top cfgld_chk #(
  .NREG(1 << ADDR_W), .FIELD_W(WORD_W - ADDR_W), .CP_ADDR(cfgld_pkg::CP_REG_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ser_le(ser_le), .lo_sel(lo_sel),
  .lo_pins_out(lo_pins_out), .lo_pins_in(lo_pins_in),
  .cp_cur_code(cp_cur_code), .cfg_words(cfg_words)
);

// File: tb/cfgld_top_tb_top.sv
`timescale 1ns/1ps
module cfgld_top_tb_top;
  localparam int FW = 21;
  localparam logic [7:0] IMPL = 8'hBF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, sle = 1'b0, lo_sel = 1'b0;
  logic [8*FW-1:0] cfg_words;
  logic lo_out, lo_in, cp_ref;
  logic [1:0] cp_code;
  logic [3:0] tviol;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfgld_top dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_dat(sdat), .ser_le(sle),
    .lo_sel(lo_sel), .cfg_words(cfg_words), .lo_pins_out(lo_out),
    .lo_pins_in(lo_in), .cp_cur_code(cp_code), .cp_ext_ref(cp_ref), .tviol(tviol)
  );

  // ---------------- behavioural reference ----------------
  logic [2:0] hq[$];
  int m_ph, m_dat, m_gap, m_le, m_hold;
  logic [23:0] m_sh;
  logic [FW-1:0] m_reg [8];
  logic [3:0] m_tv;

  function automatic int sat(int v);
    return (v > 255) ? 255 : v;
  endfunction

  always @(posedge clk) begin
    logic [2:0] cur, prv;
    bit cr, ce, dc, lr, lf;
    int stab, gapl;
    if (!rst_n) begin
      hq = '{3'b0, 3'b0, 3'b0, 3'b0};
      m_ph = 255; m_dat = 255; m_gap = 255; m_le = 0; m_hold = 0;
      m_sh = '0; m_tv = '0;
      for (int i = 0; i < 8; i++) m_reg[i] = '0;
    end else begin
      hq.push_back({sle, sdat, sclk});
      void'(hq.pop_front());
      cur = hq[1]; prv = hq[0];
      cr = cur[0] && !prv[0]; ce = cur[0] != prv[0]; dc = cur[1] != prv[1];
      lr = cur[2] && !prv[2]; lf = !cur[2] && prv[2];
      stab = dc ? 0 : m_dat + 1;
      gapl = cr ? 0 : m_gap + 1;
      m_tv[0] = ce && (m_ph + 1 < 2);
      m_tv[1] = (cr && stab < 1) || (dc && m_hold != 0);
      m_tv[2] = lr && (gapl < 1);
      m_tv[3] = lf && (m_le < 2);
      if (lr && IMPL[m_sh[2:0]]) m_reg[m_sh[2:0]] = m_sh[23:3];
      if (cr) m_sh = {m_sh[22:0], cur[1]};
      m_ph  = ce ? 0 : sat(m_ph + 1);
      m_dat = dc ? 0 : sat(m_dat + 1);
      m_gap = cr ? 0 : sat(m_gap + 1);
      if (lr) m_le = 1; else if (cur[2]) m_le = sat(m_le + 1);
      if (cr) m_hold = 1; else if (m_hold > 0) m_hold = m_hold - 1;
    end
  end

  // every-cycle comparison, away from the edge
  always @(posedge clk) begin
    logic [8*FW-1:0] ef;
    bit eo, ei;
    #2;
    if (rst_n && !done) begin
      for (int i = 0; i < 8; i++) ef[i*FW +: FW] = m_reg[i];
      eo = lo_sel || (m_reg[5][0] && !m_reg[5][1]);
      ei = !lo_sel && !m_reg[5][0] && m_reg[5][1];
      vectors++;
      if (cfg_words !== ef) begin
        fails++; $display("FAIL R2/R3 regs: got %h exp %h", cfg_words, ef);
      end
      if (lo_out !== eo || lo_in !== ei) begin
        fails++; $display("FAIL R6 lo: got %b%b exp %b%b", lo_out, lo_in, eo, ei);
      end
      if (cp_code !== m_reg[4][8:7] || cp_ref !== m_reg[4][15]) begin
        fails++; $display("FAIL R7 cp: got %b/%b exp %b/%b", cp_code, cp_ref, m_reg[4][8:7], m_reg[4][15]);
      end
      if (tviol !== m_tv) begin
        fails++; $display("FAIL R8 R9 R10 tviol: got %b exp %b", tviol, m_tv);
      end
    end
  end

  // sticky capture of violation pulses
  logic [3:0] sticky = '0;
  logic clr = 1'b0;
  always @(posedge clk) begin
    if (clr) sticky <= '0;
    else     sticky <= sticky | tviol;
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  task automatic send_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = v[i]; cyc(3);
      sclk = 1'b1; cyc(3);
      sclk = 1'b0;
    end
    cyc(3);
  endtask

  task automatic strobe();
    sle = 1'b1; cyc(3);
    sle = 1'b0; cyc(6);
  endtask

  task automatic clear_sticky();
    clr = 1'b1; cyc(1); clr = 1'b0;
  endtask

  function automatic logic [FW-1:0] slice(int a);
    return cfg_words[a*FW +: FW];
  endfunction

  // ---------------- directed sequence ----------------
  initial begin
    logic [8*FW-1:0] snap;
    cyc(3);
    // R1 reset state
    check("R1 regs", 32'(cfg_words == '0), 32'd1);
    check("R1 tviol/cp/lo_in", {25'd0, tviol, cp_code, lo_in}, 32'd0);
    rst_n = 1'b1;
    cyc(4);

    // R2 R3 R7: register 4, code 2, external reference
    clear_sticky();
    send_bits(32'h040804, 24); strobe();
    check("R2 R3 reg4 field", 32'(slice(4)), 32'h008100);
    check("R7 cp code", 32'(cp_code), 32'd2);
    check("R7 ext ref", 32'(cp_ref), 32'd1);
    check("R8 R9 R10 clean word no pulse", 32'(sticky), 32'd0);

    // R6 LO direction
    send_bits(32'h000015, 24); strobe();
    check("R6 input mode", {30'd0, lo_out, lo_in}, 32'b01);
    lo_sel = 1'b1; cyc(2);
    check("R6 sel forces out", {30'd0, lo_out, lo_in}, 32'b10);
    lo_sel = 1'b0;
    send_bits(32'h00000D, 24); strobe();
    check("R6 drive mode", {30'd0, lo_out, lo_in}, 32'b10);

    // R4 unimplemented address
    snap = cfg_words;
    send_bits(32'hFFFFFE, 24); strobe();
    check("R4 unchanged", 32'(cfg_words == snap), 32'd1);
    check("R4 slice6 zero", 32'(slice(6)), 32'd0);

    // R5 too many then too few bits
    send_bits(32'hA123453, 28); strobe();
    check("R5 extra bits", 32'(slice(3)), 32'h02468A);
    send_bits(32'h01, 8); strobe();
    check("R5 short word", 32'(slice(1)), 32'h068A60);

    // R8 short clock phase
    clear_sticky();
    sclk = 1'b1; cyc(1); sclk = 1'b0; cyc(8);
    check("R8 phase pulse", 32'(sticky[0]), 32'd1);

    // R9 setup: data moves with the clock
    clear_sticky();
    sdat = ~sdat; sclk = 1'b1; cyc(3); sclk = 1'b0; cyc(8);
    check("R9 setup pulse", 32'(sticky[1]), 32'd1);

    // R9 hold: data moves right after the clock
    clear_sticky();
    sdat = 1'b0; cyc(3); sclk = 1'b1; cyc(1); sdat = 1'b1; cyc(2); sclk = 1'b0; cyc(8);
    check("R9 hold pulse", 32'(sticky[1]), 32'd1);

    // R10 strobe with clock edge, then narrow strobe
    clear_sticky();
    sclk = 1'b1; sle = 1'b1; cyc(3); sclk = 1'b0; sle = 1'b0; cyc(8);
    check("R10 gap pulse", 32'(sticky[2]), 32'd1);
    clear_sticky();
    sle = 1'b1; cyc(1); sle = 1'b0; cyc(8);
    check("R10 width pulse", 32'(sticky[3]), 32'd1);

    cyc(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule